// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds the operand registers of a numeric coprocessor as an eight-entry circular stack. The stack pointer is not a separate register. It is a 3-bit field inside a 16-bit status word, so software reading the status word sees where the top is. Every slot carries a 2-bit tag that records whether it holds an ordinary value, a known zero, or nothing. Push and pop move the pointer and update these tags. Reads and writes address the stack relative to the top: ST(i) is physical slot (top + i) mod 8.

A ninth slot sits beside the eight stack slots. It holds a memory operand after conversion, so that arithmetic can treat it like a register. ST(i) never reaches this slot. It has its own write strobe and its own read-out. The block also holds a control word and exposes its rounding field and exception mask. The data is an opaque 64-bit word: the block does no arithmetic. Misuse of the stack sets a single sticky fault bit in the status word.

The data slots live in a memory with one write port and two registered read ports, so block RAM can be used. The tags, the status word and the control word are flip-flops.

Top module: `regstack_top`

## Requirements
- R1: A synchronous reset clears the status word to 0, which puts the pointer at 0. It sets every tag to empty (code 3). It clears `st_rd_data_o`, `round_o` and `exc_mask_o` to 0 and sets `st_rd_tag_o` and `scr_tag_o` to 3.
- R2: The pointer occupies status bits 13:11. When push or pop changes it, every status bit other than 13:11 and the fault bit 6 keeps its value. A cycle with `sw_wr_i` loads the whole status word from `sw_data_i`. In that cycle push, pop and ST writes are ignored.
- R3: A push decrements the pointer modulo 8. It stores `push_data_i` in the new top slot and tags that slot valid (code 0).
- R4: A push with `push_zero_i` high decrements the pointer the same way. It stores zero and tags the slot zero (code 1).
- R5: A pop tags the current top slot empty (code 3) and increments the pointer modulo 8. The slot's data is left unchanged.
- R6: `st_rd_data_o` and `st_rd_tag_o` show physical slot (top + `st_rd_idx_i`) mod 8, one cycle after the index is presented. They show the state as it was before that clock edge.
- R7: An ST write stores `st_wr_data_i` in slot (top + `st_wr_idx_i`) mod 8 and tags it valid. It takes effect only in a cycle with no push, no pop and no status write.
- R8: Slot 8 is written by `scr_wr_i` and tagged valid. This happens only when no push or ST write takes the memory write port in that cycle. `scr_data_o` and `scr_tag_o` show slot 8 one cycle later, and ST(i) never addresses it.
- R9: Status bit 6 is set when a push targets a slot whose tag is not empty, or when a pop finds an empty top. It stays set until reset, or until a status write that loads it as 0.
- R10: When push and pop are asserted in the same cycle, the push is performed and the pop is ignored.
- R11: `cw_wr_i` loads the control word. `round_o` then shows bits 9:8 and `exc_mask_o` shows bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push onto the stack |
| push_zero_i | input | 1 | With push_i, push an explicit zero |
| push_data_i | input | 64 | Value to push |
| pop_i | input | 1 | Pop the stack |
| st_wr_i | input | 1 | Write ST(i) |
| st_wr_idx_i | input | 3 | Relative index for the write |
| st_wr_data_i | input | 64 | Data for the write |
| st_rd_idx_i | input | 3 | Relative index for the read |
| st_rd_data_o | output | 64 | Registered data of ST(i) |
| st_rd_tag_o | output | 2 | Registered tag of ST(i) |
| scr_wr_i | input | 1 | Write the scratch slot |
| scr_data_i | input | 64 | Converted operand for the scratch slot |
| scr_data_o | output | 64 | Registered scratch slot data |
| scr_tag_o | output | 2 | Registered scratch slot tag |
| sw_wr_i | input | 1 | Load the whole status word |
| sw_data_i | input | 16 | Status word to load |
| sw_o | output | 16 | Status word, pointer in bits 13:11, fault in bit 6 |
| cw_wr_i | input | 1 | Load the control word |
| cw_i | input | 16 | Control word to load |
| round_o | output | 2 | Rounding field of the control word |
| exc_mask_o | output | 6 | Exception mask of the control word |

## Verification
Push and pop can be requested in the same cycle. So can a push and a slot tag that is already occupied, which makes the pointer move and the fault bit rise on one edge. A directed step asserts push and pop together on a known stack. A second directed step pushes a ninth value without any pops, so the wrap lands on a slot that is still full. The random phase also draws push and pop independently, which repeats the overlap many times. Each result is judged against a bench model on three things: the pointer field must move down by exactly one, the pushed slot must read back with the pushed tag, and the fault bit must follow the occupancy of the target slot.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef logic [1:0] tag_t;
  localparam tag_t TAG_VALID = 2'd0;
  localparam tag_t TAG_ZERO  = 2'd1;
  localparam tag_t TAG_EMPTY = 2'd3;
endpackage

// File: rtl/regstack_ptr.sv
module regstack_ptr #(
  parameter int SW_W      = 16,
  parameter int PTR_W     = 3,
  parameter int PTR_LSB   = 11,
  parameter int FAULT_BIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [SW_W-1:0]  sw_wdata,
  input  logic             push,
  input  logic             pop,
  input  logic             fault_set,
  output logic [SW_W-1:0]  sw_q,
  output logic [PTR_W-1:0] top
);
  localparam logic [SW_W-1:0] PTR_MASK   = SW_W'(((1 << PTR_W) - 1) << PTR_LSB);
  localparam logic [SW_W-1:0] FAULT_MASK = SW_W'(1) << FAULT_BIT;
  localparam logic [SW_W-1:0] KEEP_MASK  = ~(PTR_MASK | FAULT_MASK);

  assign top = sw_q[PTR_LSB +: PTR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= '0;
    end else if (sw_wr) begin
      sw_q <= sw_wdata;
    end else begin
      if (push)     sw_q[PTR_LSB +: PTR_W] <= top - PTR_W'(1);
      else if (pop) sw_q[PTR_LSB +: PTR_W] <= top + PTR_W'(1);
      if (fault_set) sw_q[FAULT_BIT] <= 1'b1;
    end
  end

  // R2
  keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> ((sw_q & KEEP_MASK) == ($past(sw_q) & KEEP_MASK)));
  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !sw_wr) |=> (top == PTR_W'($past(top) - PTR_W'(1))));
  // R5
  pop_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !sw_wr) |=> (top == PTR_W'($past(top) + PTR_W'(1))));
  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr && sw_q[FAULT_BIT]) |=> sw_q[FAULT_BIT]);
endmodule

// File: rtl/regstack_tags.sv
module regstack_tags
  import regstack_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  tag_t          set_val,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic [AW-1:0] pa_idx,
  output tag_t          pa_tag,
  input  logic [AW-1:0] pb_idx,
  output tag_t          pb_tag,
  input  logic [AW-1:0] ra_idx,
  output tag_t          ra_tag_q,
  input  logic [AW-1:0] rb_idx,
  output tag_t          rb_tag_q
);
  tag_t tags_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) tags_q[i] <= TAG_EMPTY;
      ra_tag_q <= TAG_EMPTY;
      rb_tag_q <= TAG_EMPTY;
    end else begin
      if (set_en) tags_q[set_idx] <= set_val;
      if (clr_en) tags_q[clr_idx] <= TAG_EMPTY;
      ra_tag_q <= tags_q[ra_idx];
      rb_tag_q <= tags_q[rb_idx];
    end
  end

  assign pa_tag = tags_q[pa_idx];
  assign pb_tag = tags_q[pb_idx];

  // R3 R4 R7 R8
  tag_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (tags_q[$past(set_idx)] == $past(set_val)));
  // R5
  tag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (tags_q[$past(clr_idx)] == TAG_EMPTY));
endmodule

// File: rtl/regstack_ram.sv
module regstack_ram #(
  parameter int DATA_W = 64,
  parameter int SLOTS  = 9,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_q,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_q
);
  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      ra_q <= mem[ra_addr];
      rb_q <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/regstack_top.sv
module regstack_top
  import regstack_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 8,
  parameter int SW_W      = 16,
  parameter int PTR_LSB   = 11,
  parameter int FAULT_BIT = 6,
  parameter int RND_LSB   = 8,
  parameter int RND_W     = 2,
  parameter int MASK_W    = 6,
  localparam int PW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              push_zero_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              st_wr_i,
  input  logic [PW-1:0]     st_wr_idx_i,
  input  logic [DATA_W-1:0] st_wr_data_i,
  input  logic [PW-1:0]     st_rd_idx_i,
  output logic [DATA_W-1:0] st_rd_data_o,
  output logic [1:0]        st_rd_tag_o,
  input  logic              scr_wr_i,
  input  logic [DATA_W-1:0] scr_data_i,
  output logic [DATA_W-1:0] scr_data_o,
  output logic [1:0]        scr_tag_o,
  input  logic              sw_wr_i,
  input  logic [SW_W-1:0]   sw_data_i,
  output logic [SW_W-1:0]   sw_o,
  input  logic              cw_wr_i,
  input  logic [SW_W-1:0]   cw_i,
  output logic [RND_W-1:0]  round_o,
  output logic [MASK_W-1:0] exc_mask_o
);
  localparam int SLOTS = DEPTH + 1;
  localparam int AW    = $clog2(SLOTS);
  localparam logic [AW-1:0] SCR_ADDR = AW'(DEPTH);

  logic [PW-1:0]     top, new_top;
  logic              push_eff, pop_eff, stw_eff, scr_eff, fault_set;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;
  tag_t              wtag, push_tgt_tag, top_tag;
  logic [AW-1:0]     top_addr, new_top_addr, rd_addr;

  assign push_eff = push_i & ~sw_wr_i;
  assign pop_eff  = pop_i & ~push_i & ~sw_wr_i;
  assign stw_eff  = st_wr_i & ~push_i & ~pop_i & ~sw_wr_i;
  assign scr_eff  = scr_wr_i & ~push_eff & ~stw_eff;

  assign new_top      = top - PW'(1);
  assign top_addr     = AW'(top);
  assign new_top_addr = AW'(new_top);
  assign rd_addr      = AW'(PW'(top + st_rd_idx_i));

  always_comb begin
    we    = 1'b0;
    waddr = SCR_ADDR;
    wdata = scr_data_i;
    wtag  = TAG_VALID;
    if (push_eff) begin
      we    = 1'b1;
      waddr = new_top_addr;
      wdata = push_zero_i ? '0 : push_data_i;
      wtag  = push_zero_i ? TAG_ZERO : TAG_VALID;
    end else if (stw_eff) begin
      we    = 1'b1;
      waddr = AW'(PW'(top + st_wr_idx_i));
      wdata = st_wr_data_i;
    end else if (scr_eff) begin
      we    = 1'b1;
    end
  end

  assign fault_set = (push_eff && (push_tgt_tag != TAG_EMPTY)) ||
                     (pop_eff && (top_tag == TAG_EMPTY));

  regstack_ptr #(.SW_W(SW_W), .PTR_W(PW), .PTR_LSB(PTR_LSB), .FAULT_BIT(FAULT_BIT)) u_ptr (
    .clk(clk), .rst(rst), .sw_wr(sw_wr_i), .sw_wdata(sw_data_i),
    .push(push_eff), .pop(pop_eff), .fault_set(fault_set),
    .sw_q(sw_o), .top(top)
  );

  regstack_tags #(.SLOTS(SLOTS), .AW(AW)) u_tags (
    .clk(clk), .rst(rst),
    .set_en(we), .set_idx(waddr), .set_val(wtag),
    .clr_en(pop_eff), .clr_idx(top_addr),
    .pa_idx(new_top_addr), .pa_tag(push_tgt_tag),
    .pb_idx(top_addr), .pb_tag(top_tag),
    .ra_idx(rd_addr), .ra_tag_q(st_rd_tag_o),
    .rb_idx(SCR_ADDR), .rb_tag_q(scr_tag_o)
  );

  regstack_ram #(.DATA_W(DATA_W), .SLOTS(SLOTS), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .ra_addr(rd_addr), .ra_q(st_rd_data_o),
    .rb_addr(SCR_ADDR), .rb_q(scr_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      round_o    <= '0;
      exc_mask_o <= '0;
    end else if (cw_wr_i) begin
      round_o    <= cw_i[RND_LSB +: RND_W];
      exc_mask_o <= cw_i[MASK_W-1:0];
    end
  end

  logic cw_unused;
  assign cw_unused = ^{cw_i};

  // R10
  push_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !sw_wr_i) |=> (sw_o[PTR_LSB +: PW] == PW'($past(top) - PW'(1))));
  // R9
  fault_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_set && !sw_wr_i) |=> sw_o[FAULT_BIT]);
  // R11
  cw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cw_wr_i |=> ($stable(round_o) && $stable(exc_mask_o)));
endmodule

// File: tb/regstack_top_bench.sv
module regstack_top_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push, pz, pop, stwr, scrwr, swwr, cwwr;
  logic [63:0] pd, wd, sd;
  logic [2:0]  widx, ridx;
  logic [15:0] swd, cwd;
  logic [63:0] st_rd_data, scr_data;
  logic [1:0]  st_rd_tag, scr_tag;
  logic [15:0] sw;
  logic [1:0]  rnd;
  logic [5:0]  emask;

  int nchk = 0;
  int nfail = 0;

  logic [15:0] m_sw;
  logic [1:0]  m_tag [9];
  logic [63:0] m_dat [9];
  bit          m_kn  [9];
  logic [1:0]  m_rnd;
  logic [5:0]  m_mask;

  always #(CLK_P/2) clk = ~clk;

  regstack_top u_regstack_top (
    .clk(clk), .rst(rst),
    .push_i(push), .push_zero_i(pz), .push_data_i(pd), .pop_i(pop),
    .st_wr_i(stwr), .st_wr_idx_i(widx), .st_wr_data_i(wd),
    .st_rd_idx_i(ridx), .st_rd_data_o(st_rd_data), .st_rd_tag_o(st_rd_tag),
    .scr_wr_i(scrwr), .scr_data_i(sd), .scr_data_o(scr_data), .scr_tag_o(scr_tag),
    .sw_wr_i(swwr), .sw_data_i(swd), .sw_o(sw),
    .cw_wr_i(cwwr), .cw_i(cwd), .round_o(rnd), .exc_mask_o(emask)
  );

  task automatic chk(input bit ok, input string lbl, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
    end
  endtask

  task automatic idle_in();
    push = 0; pz = 0; pop = 0; stwr = 0; scrwr = 0; swwr = 0; cwwr = 0;
    pd = '0; wd = '0; sd = '0; widx = '0; ridx = '0; swd = '0; cwd = '0;
  endtask

  function automatic int mtop();
    return int'(m_sw[13:11]);
  endfunction

  // One clock: inputs already driven; model computes expected values independently.
  task automatic step(input string lbl);
    int p, nt, t;
    logic [63:0] e_rd, e_sd;
    logic [1:0]  e_rt, e_st;
    bit e_rk, e_sk, push_e, stw_e;
    p = (mtop() + int'(ridx)) & 7;
    e_rd = m_dat[p]; e_rk = m_kn[p]; e_rt = m_tag[p];
    e_sd = m_dat[8]; e_sk = m_kn[8]; e_st = m_tag[8];
    push_e = push && !swwr;
    stw_e  = stwr && !push && !pop && !swwr;
    t = mtop();
    if (swwr) begin
      m_sw = swd;
    end else if (push) begin
      nt = (t - 1) & 7;
      if (m_tag[nt] != 2'd3) m_sw[6] = 1'b1;
      m_dat[nt] = pz ? 64'd0 : pd;
      m_kn[nt] = 1;
      m_tag[nt] = pz ? 2'd1 : 2'd0;
      m_sw[13:11] = 3'(nt);
    end else if (pop) begin
      if (m_tag[t] == 2'd3) m_sw[6] = 1'b1;
      m_tag[t] = 2'd3;
      m_sw[13:11] = 3'((t + 1) & 7);
    end else if (stwr) begin
      nt = (t + int'(widx)) & 7;
      m_dat[nt] = wd; m_kn[nt] = 1; m_tag[nt] = 2'd0;
    end
    if (scrwr && !push_e && !stw_e) begin
      m_dat[8] = sd; m_kn[8] = 1; m_tag[8] = 2'd0;
    end
    if (cwwr) begin
      m_rnd = cwd[9:8]; m_mask = cwd[5:0];
    end
    @(posedge clk);
    @(negedge clk);
    chk(sw == m_sw, {lbl, " status R2/R9"}, 64'(sw), 64'(m_sw));
    chk(st_rd_tag == e_rt, {lbl, " read tag R6"}, 64'(st_rd_tag), 64'(e_rt));
    if (e_rk) chk(st_rd_data == e_rd, {lbl, " read data R6"}, st_rd_data, e_rd);
    chk(scr_tag == e_st, {lbl, " scratch tag R8"}, 64'(scr_tag), 64'(e_st));
    if (e_sk) chk(scr_data == e_sd, {lbl, " scratch data R8"}, scr_data, e_sd);
    chk({rnd, emask} == {m_rnd, m_mask}, {lbl, " control R11"}, 64'({rnd, emask}), 64'({m_rnd, m_mask}));
    idle_in();
  endtask

  task automatic read_all(input string lbl);
    for (int i = 0; i < 8; i++) begin
      ridx = 3'(i);
      step(lbl);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_in();
    m_sw = '0; m_rnd = '0; m_mask = '0;
    for (int i = 0; i < 9; i++) begin m_tag[i] = 2'd3; m_dat[i] = '0; m_kn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sw == 16'h0, "R1 status", 64'(sw), 64'h0);
    chk(st_rd_tag == 2'd3, "R1 read tag", 64'(st_rd_tag), 64'd3);
    chk(st_rd_data == 64'd0, "R1 read data", st_rd_data, 64'd0);
    chk(scr_tag == 2'd3, "R1 scratch tag", 64'(scr_tag), 64'd3);
    chk({rnd, emask} == 8'd0, "R1 control", 64'({rnd, emask}), 64'd0);
    read_all("R1 all empty");

    // R3 pushes, R4 zero push
    push = 1; pd = 64'h1111_0000_0000_0001; step("R3 push");
    chk(sw[13:11] == 3'd7, "R3 pointer wrap to 7", 64'(sw[13:11]), 64'd7);
    push = 1; pd = 64'h2222_0000_0000_0002; step("R3 push");
    push = 1; pz = 1; pd = 64'hdead; step("R4 zero push");
    chk(sw[13:11] == 3'd5, "R4 pointer", 64'(sw[13:11]), 64'd5);
    read_all("R6 after pushes");

    // R5 pop, then R10 push and pop together
    pop = 1; step("R5 pop");
    push = 1; pop = 1; pd = 64'h3333; step("R10 push beats pop");
    chk(sw[13:11] == 3'd5, "R10 pointer", 64'(sw[13:11]), 64'd5);
    read_all("R10 readback");

    // R7 relative write, and writes ignored beside pop
    stwr = 1; widx = 3'd1; wd = 64'h7777; step("R7 write ST(1)");
    stwr = 1; pop = 1; widx = 3'd0; wd = 64'hbad; step("R7 write ignored with pop");
    read_all("R7 readback");

    // R8 scratch, blocked by push
    scrwr = 1; sd = 64'h8888; step("R8 scratch write");
    scrwr = 1; push = 1; sd = 64'h9999; pd = 64'h4444; step("R8 scratch blocked");
    step("R8 scratch hold");

    // R11 control word
    cwwr = 1; cwd = 16'hF2A5; step("R11 control load");

    // R2 status load ignores push, preserves other bits across moves
    swwr = 1; swd = 16'h8285; push = 1; pd = 64'h5; step("R2 status load");
    push = 1; pd = 64'h55; step("R2 push keeps bits");
    pop = 1; step("R2 pop keeps bits");

    // R9 fault: clear, fill all eight, ninth push faults
    swwr = 1; swd = 16'h0000; step("R9 clear");
    for (int i = 0; i < 8; i++) begin push = 1; pd = 64'(i + 100); step("R9 fill"); end
    push = 1; pd = 64'hfeed; step("R9 push onto full");
    chk(sw[6] == 1'b1, "R9 fault after overfull push", 64'(sw[6]), 64'd1);
    swwr = 1; swd = 16'h0000; step("R9 clear");
    for (int i = 0; i < 8; i++) begin pop = 1; step("R9 drain"); end
    chk(sw[6] == 1'b0, "R9 no fault on full drain", 64'(sw[6]), 64'd0);
    pop = 1; step("R9 pop on empty");
    chk(sw[6] == 1'b1, "R9 fault on empty pop", 64'(sw[6]), 64'd1);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      push  = ($urandom % 100) < 30;
      pz    = ($urandom % 4) == 0;
      pop   = ($urandom % 100) < 30;
      stwr  = ($urandom % 100) < 20;
      scrwr = ($urandom % 100) < 20;
      swwr  = ($urandom % 100) < 3;
      cwwr  = ($urandom % 100) < 5;
      pd = {$urandom, $urandom}; wd = {$urandom, $urandom}; sd = {$urandom, $urandom};
      widx = 3'($urandom); ridx = 3'($urandom);
      swd = 16'($urandom); cwd = 16'($urandom);
      step("R6 random");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule